// File: doc/BRIEF.md
# Refresh Timing Parameter Calculator

This block turns a DRAM clock frequency, given in whole MHz, into the two refresh timing counts that a memory controller needs. The first is the refresh-cycle time (tRFC), which sets how long the controller waits after a refresh command. The second is the average refresh interval (tREFI), which sets how often a refresh command is issued. Both counts are in DRAM clock cycles. tRFC depends on the memory family (DDR2 or DDR3) and on the device density. The block holds a small table of tRFC durations, each a nanosecond figure pre-scaled by 1024/1000. It multiplies the chosen entry by the clock frequency and divides by 1024 with a right shift.

A requester presents the frequency, the memory family and a density code together with a one-cycle strobe. One clock later the block returns both counts and a single-cycle result-valid pulse. The counts then stay unchanged until the next strobe. The block is used once during memory bring-up, or whenever the DRAM clock is retuned. Its outputs go to whatever logic programs the refresh engine.

Top module: `refresh_timing_calc`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `res_valid` is 0 and both `trfc_cycles` and `trefi_cycles` are 0.
- R2: `res_valid` is 1 in exactly the cycle after a clock edge at which `req_valid` was sampled high, and is 0 otherwise. Strobes on consecutive cycles give results on consecutive cycles.
- R3: `trfc_cycles` equals (T × `clock_mhz` + 1023) >> 10, where T is the table entry selected by `mem_type` and `density_code`. This is the division by 1024 rounded up.
- R4: `trefi_cycles` equals (7987 × `clock_mhz`) >> 10, truncated. It does not depend on `mem_type` or `density_code`.
- R5: With `mem_type` = 0 (DDR2), density codes 0 to 5 (256Mb, 512Mb, 1Gb, 2Gb, 4Gb, 8Gb) select T = 77, 108, 131, 200, 336 and 336. The 8Gb entry is a fill value.
- R6: With `mem_type` = 1 (DDR3), density codes 0 to 5 select T = 93, 93, 113, 164, 308 and 359. The 256Mb entry is a fill value.
- R7: Density codes 6 and 7 produce the same result as code 0 (256Mb) for the same family and frequency.
- R8: Results are exact over the whole 10-bit frequency range. At `clock_mhz` = 1023, DDR3 8Gb gives tRFC 359 and tREFI 7979, with no wrap of the intermediate product.
- R9: In a cycle that follows an edge with `req_valid` low, `trfc_cycles` and `trefi_cycles` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | One-cycle request strobe |
| clock_mhz | input | 10 | DRAM clock frequency in MHz |
| mem_type | input | 1 | Memory family: 0 = DDR2, 1 = DDR3 |
| density_code | input | 3 | Device density code (0..5; 6 and 7 treated as 0) |
| trfc_cycles | output | 14 | Refresh-cycle time in DRAM clocks |
| trefi_cycles | output | 14 | Refresh interval in DRAM clocks |
| res_valid | output | 1 | Single-cycle pulse marking fresh results |

## Verification
The hardest cases to reach are the edges of the rounding. tRFC must round up, and tREFI must round down, only when the product is not a multiple of 1024. The top of the frequency range must also be covered, where a narrow product would wrap. Both show up only for particular frequency values. The stimulus therefore sweeps every `clock_mhz` value from 0 to 1023 for every family and every one of the eight density codes, including the two unmapped ones. For each input set the bench computes the expected counts with integer arithmetic. A burst of back-to-back strobes, and idle cycles with the inputs changing, exercise the pulse and hold behaviour.

// File: rtl/refcalc_pkg.sv
package refcalc_pkg;

    localparam int MHZ_W     = 10;
    localparam int NS_W      = 9;
    localparam int COEF_W    = 13;
    localparam int DENS_W    = 3;
    localparam int SHIFT     = 10;
    localparam int PROD_W    = 24;
    localparam int RES_W     = PROD_W - SHIFT;
    localparam int REFI_COEF = 7987;

    typedef enum logic {
        MEM_DDR2 = 1'b0,
        MEM_DDR3 = 1'b1
    } mem_kind_e;

    typedef enum logic [DENS_W-1:0] {
        DEN_256M = 3'd0,
        DEN_512M = 3'd1,
        DEN_1G   = 3'd2,
        DEN_2G   = 3'd3,
        DEN_4G   = 3'd4,
        DEN_8G   = 3'd5
    } density_e;

    typedef struct packed {
        logic [RES_W-1:0] trfc;
        logic [RES_W-1:0] trefi;
    } refresh_timing_t;

    // Codes beyond the last defined density fall back to the smallest part.
    function automatic density_e norm_density(input logic [DENS_W-1:0] code);
        if (code > 3'd5)
            return DEN_256M;
        return density_e'(code);
    endfunction

    // tRFC in nanoseconds scaled by 1024/1000, rounded up.
    function automatic logic [NS_W-1:0] trfc_scaled(input mem_kind_e kind, input density_e den);
        logic [NS_W-1:0] v;
        if (kind == MEM_DDR3) begin
            case (den)
                DEN_256M: v = 9'd93;
                DEN_512M: v = 9'd93;
                DEN_1G:   v = 9'd113;
                DEN_2G:   v = 9'd164;
                DEN_4G:   v = 9'd308;
                default:  v = 9'd359;
            endcase
        end else begin
            case (den)
                DEN_256M: v = 9'd77;
                DEN_512M: v = 9'd108;
                DEN_1G:   v = 9'd131;
                DEN_2G:   v = 9'd200;
                DEN_4G:   v = 9'd336;
                default:  v = 9'd336;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/refcalc_lookup.sv
module refcalc_lookup
    import refcalc_pkg::*;
(
    input  logic              kind_i,
    input  logic [DENS_W-1:0] dens_code_i,
    output logic [NS_W-1:0]   scaled_ns_o
);

    density_e den_n;

    always_comb begin
        den_n       = norm_density(dens_code_i);
        scaled_ns_o = trfc_scaled(mem_kind_e'(kind_i), den_n);
    end

endmodule

// File: rtl/refcalc_scale.sv
module refcalc_scale #(
    parameter int  COEF_W   = 13,
    parameter int  MHZ_W    = 10,
    parameter int  PROD_W   = 24,
    parameter int  SHIFT    = 10,
    parameter bit  ROUND_UP = 1'b0,
    localparam int RES_W    = PROD_W - SHIFT
) (
    input  logic [COEF_W-1:0] coef_i,
    input  logic [MHZ_W-1:0]  mhz_i,
    output logic [RES_W-1:0]  res_o
);

    localparam logic [PROD_W-1:0] BIAS = PROD_W'((1 << SHIFT) - 1);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] biased;

    assign prod = PROD_W'(coef_i) * PROD_W'(mhz_i);

    generate
        if (ROUND_UP) begin : g_ceil
            assign biased = prod + BIAS;
        end else begin : g_floor
            assign biased = prod;
        end
    endgenerate

    assign res_o = RES_W'(biased >> SHIFT);

endmodule

// File: rtl/refresh_timing_calc.sv
module refresh_timing_calc
    import refcalc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [MHZ_W-1:0]         clock_mhz,
    input  logic                     mem_type,
    input  logic [DENS_W-1:0]        density_code,
    output logic [RES_W-1:0]         trfc_cycles,
    output logic [RES_W-1:0]         trefi_cycles,
    output logic                     res_valid
);

    logic [NS_W-1:0]  scaled_ns;
    refresh_timing_t  next_t;
    refresh_timing_t  held_t;
    logic             valid_q;

    refcalc_lookup u_lookup (
        .kind_i      (mem_type),
        .dens_code_i (density_code),
        .scaled_ns_o (scaled_ns)
    );

    refcalc_scale #(
        .COEF_W   (COEF_W),
        .MHZ_W    (MHZ_W),
        .PROD_W   (PROD_W),
        .SHIFT    (SHIFT),
        .ROUND_UP (1'b1)
    ) u_trfc (
        .coef_i (COEF_W'(scaled_ns)),
        .mhz_i  (clock_mhz),
        .res_o  (next_t.trfc)
    );

    refcalc_scale #(
        .COEF_W   (COEF_W),
        .MHZ_W    (MHZ_W),
        .PROD_W   (PROD_W),
        .SHIFT    (SHIFT),
        .ROUND_UP (1'b0)
    ) u_trefi (
        .coef_i (COEF_W'(REFI_COEF)),
        .mhz_i  (clock_mhz),
        .res_o  (next_t.trefi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_t  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= req_valid;
            if (req_valid)
                held_t <= next_t;
        end
    end

    assign trfc_cycles  = held_t.trfc;
    assign trefi_cycles = held_t.trefi;
    assign res_valid    = valid_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(trfc_cycles) && $stable(trefi_cycles))); // R9
    AST_REFI_FLOOR: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (32'(trefi_cycles) * 32'd1024 <= 32'(REFI_COEF) * 32'($past(clock_mhz)))); // R4
    AST_REFI_TIGHT: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (32'(trefi_cycles) * 32'd1024 + 32'd1024 > 32'(REFI_COEF) * 32'($past(clock_mhz)))); // R4
    AST_TRFC_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(clock_mhz) != '0) |-> (trfc_cycles != '0)); // R3
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!res_valid && trfc_cycles == '0 && trefi_cycles == '0)); // R1

endmodule

// File: tb/test_refresh_timing_calc.sv
`timescale 1ns/1ps
module test_refresh_timing_calc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [9:0]  clock_mhz = '0;
    logic        mem_type = 1'b0;
    logic [2:0]  density_code = '0;
    logic [13:0] trfc_cycles;
    logic [13:0] trefi_cycles;
    logic        res_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    refresh_timing_calc i_refresh_timing_calc (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .clock_mhz    (clock_mhz),
        .mem_type     (mem_type),
        .density_code (density_code),
        .trfc_cycles  (trfc_cycles),
        .trefi_cycles (trefi_cycles),
        .res_valid    (res_valid)
    );

    function automatic int table_ns(int ty, int dn);
        int d;
        d = (dn > 5) ? 0 : dn;
        if (ty == 1) begin
            case (d)
                0: return 93;  1: return 93;  2: return 113;
                3: return 164; 4: return 308; default: return 359;
            endcase
        end
        case (d)
            0: return 77;  1: return 108; 2: return 131;
            3: return 200; 4: return 336; default: return 336;
        endcase
    endfunction

    function automatic int exp_trfc(int ty, int dn, int mhz);
        return (table_ns(ty, dn) * mhz + 1023) / 1024;
    endfunction

    function automatic int exp_trefi(int mhz);
        return (7987 * mhz) / 1024;
    endfunction

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic drive(int ty, int dn, int mhz, bit v);
        mem_type     = ty[0];
        density_code = dn[2:0];
        clock_mhz    = mhz[9:0];
        req_valid    = v;
    endtask

    initial begin
        int last_rfc;
        int last_refi;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state, even with a strobe present
        drive(1, 5, 1023, 1'b1);
        @(negedge clk);
        check("R1 valid", int'(res_valid), 0);
        check("R1 trfc", int'(trfc_cycles), 0);
        check("R1 trefi", int'(trefi_cycles), 0);
        rst = 1'b0;
        drive(0, 0, 0, 1'b0);
        @(negedge clk);
        check("R1 idle valid", int'(res_valid), 0);

        // R3 R4 R5 R6 R7 R8: exhaustive sweep, with R2 pulse and R9 hold
        for (int ty = 0; ty < 2; ty++) begin
            for (int dn = 0; dn < 8; dn++) begin
                for (int mhz = 0; mhz < 1024; mhz++) begin
                    drive(ty, dn, mhz, 1'b1);
                    @(negedge clk);
                    check("R2 pulse", int'(res_valid), 1);
                    check(ty == 1 ? (dn > 5 ? "R7 R6 trfc" : "R6 R3 trfc")
                                  : (dn > 5 ? "R7 R5 trfc" : "R5 R3 trfc"),
                          int'(trfc_cycles), exp_trfc(ty, dn, mhz));
                    check("R4 trefi", int'(trefi_cycles), exp_trefi(mhz));
                    drive(1 - ty, 7 - dn, 1023 - mhz, 1'b0);
                    @(negedge clk);
                    check("R2 low", int'(res_valid), 0);
                    check("R9 trfc hold", int'(trfc_cycles), exp_trfc(ty, dn, mhz));
                    check("R9 trefi hold", int'(trefi_cycles), exp_trefi(mhz));
                end
            end
        end

        // R8: top of range, explicit values
        drive(1, 5, 1023, 1'b1);
        @(negedge clk);
        check("R8 trfc max", int'(trfc_cycles), 359);
        check("R8 trefi max", int'(trefi_cycles), 7979);

        // R2: back-to-back strobes update every cycle
        for (int k = 0; k < 16; k++) begin
            drive(k % 2, k % 8, 100 + 37 * k, 1'b1);
            @(negedge clk);
            check("R2 burst valid", int'(res_valid), 1);
            check("R2 burst trfc", int'(trfc_cycles), exp_trfc(k % 2, k % 8, 100 + 37 * k));
        end
        last_rfc  = exp_trfc(1, 7, 100 + 37 * 15);
        last_refi = exp_trefi(100 + 37 * 15);
        drive(0, 4, 999, 1'b0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check("R2 after burst", int'(res_valid), 0);
            check("R9 idle trfc", int'(trfc_cycles), last_rfc);
            check("R9 idle trefi", int'(trefi_cycles), last_refi);
            drive(k % 2, k, 50 * k, 1'b0);
        end

        // R1: reset mid-run clears results
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 rerst trfc", int'(trfc_cycles), 0);
        check("R1 rerst valid", int'(res_valid), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule